// File: doc/BRIEF.md
# Scale Parameter Calculator

This block takes one plane placement request and works out the settings a display scaler needs for it. The request gives the source rectangle in 16.16 fixed point (x, y, width, height), the destination width and height in whole pixels, and a flag that marks the plane as a cursor. The block first checks that the request is legal. It then decides for each axis whether the image is magnified, reduced or passed through unchanged.

From that classification it produces four things:
- a 3-bit mode code and a unity flag;
- a 16.16 step factor for each scaled axis;
- a reciprocal of the step factor for each reduced axis;
- the number of line-buffer bytes that the vertical stage will need.

All divisions go through one shared iterative divider, one after another. A request costs a few cycles when no axis is scaled and about 140 cycles in the worst case.

A request is accepted on a valid/ready handshake. The result comes out as a one-cycle `out_valid` pulse together with an error flag. The result fields then hold their values until the next result is published.

Top module: `scale_param_calc`

## Requirements
- R1: Each axis is classified by comparing destination with source integer size. Larger destination means magnify, smaller means reduce, and equal means pass-through.
- R2: `out_code` follows this table (horizontal/vertical → code):
  - magnify/magnify → 0
  - reduce/magnify → 1
  - magnify/reduce → 2
  - reduce/reduce → 3
  - magnify/pass → 4
  - pass/magnify → 5
  - pass/reduce → 6
  - reduce/pass → 7
- R3: When both axes pass through, `out_unity` is 1, `out_code` is 0 and `out_lb_size` is 0. In every other case `out_unity` is 0.
- R4: A request whose source x, y, width or height has any nonzero bit in its low 16 (fraction) bits is rejected with `out_err` = 1. For a legal request, the integer size is bits [31:16].
- R5: A request with `is_cursor` = 1 that is not unity is rejected. A cursor request that is unity is accepted.
- R6: A request with a destination width or height of zero is rejected.
- R7: The scale on each axis is floor(65536 × src / dst), where src is the source integer size and dst the destination size.
  - A reduce axis reports the low 21 bits of the scale.
  - A magnify axis reports the low 17 bits.
  - A pass-through axis reports 0.
- R8: For a reduce axis, the reciprocal output is the low 16 bits of floor(0xFFFFFFFF / full scale). For any other axis it is 0.
- R9: For a non-unity request, let m = max(source width, destination width).
  - The line-buffer size is m × 8 when the vertical axis reduces, and m × 16 otherwise.
  - The result is rounded up to a multiple of 32.
- R10: Handshake and timing:
  - `in_ready` is 1 only while no request is in progress, and `in_valid` has no effect while it is 0.
  - `out_valid` is a single-cycle pulse, and `in_ready` is 1 again in that cycle.
  - For a rejected request, the pulse comes 1 cycle after the accepting edge.
  - Otherwise it comes 6 + 33 × N cycles after it, where N counts one division per non-pass axis plus one per reduce axis.
- R11: A rejected request reports `out_err` = 1 with every other result field equal to 0.
- R12: Result outputs change only on the edge that raises `out_valid`, and hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request taken on this edge if valid |
| src_x | input | 32 | Source left edge, 16.16 |
| src_y | input | 32 | Source top edge, 16.16 |
| src_w | input | 32 | Source width, 16.16 |
| src_h | input | 32 | Source height, 16.16 |
| dst_w | input | 16 | Destination width, pixels |
| dst_h | input | 16 | Destination height, pixels |
| is_cursor | input | 1 | Request belongs to a cursor plane |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Request rejected |
| out_code | output | 3 | Scaler mode code |
| out_unity | output | 1 | No scaling on either axis |
| out_h_scale | output | 21 | Horizontal step factor |
| out_v_scale | output | 21 | Vertical step factor |
| out_h_recip | output | 16 | Horizontal reciprocal |
| out_v_recip | output | 16 | Vertical reciprocal |
| out_lb_size | output | 21 | Line-buffer bytes |

## Verification
The bench builds the block with its default widths: 16 integer and 16 fraction bits, a 21-bit reduce field, a 17-bit magnify field and a 16-bit reciprocal. With these widths, large reduction ratios reach the point where the 21-bit scale field wraps. They also let the reciprocal be taken from the full, untruncated quotient. Source and destination sizes near the 16-bit limit exercise the widest line-buffer products. Every one of the eight mode combinations is driven, as are each rejection cause and a request held at the input while the block is busy.

// File: rtl/scale_calc_pkg.sv
package scale_calc_pkg;

    typedef enum logic [1:0] {
        AX_PASS = 2'd0,
        AX_UP   = 2'd1,
        AX_DOWN = 2'd2
    } axis_mode_e;

    typedef struct packed {
        logic       err;
        axis_mode_e hm;
        axis_mode_e vm;
        logic [2:0] code;
        logic       unity;
    } cls_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_DONE
    } calc_state_e;

    localparam logic [2:0] OP_HSCALE = 3'd0;
    localparam logic [2:0] OP_VSCALE = 3'd1;
    localparam logic [2:0] OP_HRECIP = 3'd2;
    localparam logic [2:0] OP_VRECIP = 3'd3;
    localparam logic [2:0] OP_END    = 3'd4;

    function automatic logic [2:0] pick_code(axis_mode_e h, axis_mode_e v);
        logic [2:0] c;
        c = 3'd0;
        unique case ({h, v})
            {AX_UP,   AX_UP  }: c = 3'd0;
            {AX_DOWN, AX_UP  }: c = 3'd1;
            {AX_UP,   AX_DOWN}: c = 3'd2;
            {AX_DOWN, AX_DOWN}: c = 3'd3;
            {AX_UP,   AX_PASS}: c = 3'd4;
            {AX_PASS, AX_UP  }: c = 3'd5;
            {AX_PASS, AX_DOWN}: c = 3'd6;
            {AX_DOWN, AX_PASS}: c = 3'd7;
            default:            c = 3'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scale_classify.sv
module scale_classify
    import scale_calc_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16,
    localparam int COORD_W = INT_W + FRAC_W,
    localparam int LB_W    = INT_W + 5
) (
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] src_w,
    input  logic [COORD_W-1:0] src_h,
    input  logic [INT_W-1:0]   dst_w,
    input  logic [INT_W-1:0]   dst_h,
    input  logic               is_cursor,
    output cls_t               cls,
    output logic [LB_W-1:0]    lb_size
);
    logic [INT_W-1:0]   sw_int, sh_int, pix;
    logic               frac_bad;
    logic [INT_W+3:0]   pix_mul;
    logic [LB_W-1:0]    lb_raw;

    assign sw_int = src_w[COORD_W-1:FRAC_W];
    assign sh_int = src_h[COORD_W-1:FRAC_W];

    assign frac_bad = (|src_x[FRAC_W-1:0]) | (|src_y[FRAC_W-1:0]) |
                      (|src_w[FRAC_W-1:0]) | (|src_h[FRAC_W-1:0]);

    always_comb begin
        cls.hm    = (dst_w > sw_int) ? AX_UP : (dst_w < sw_int) ? AX_DOWN : AX_PASS;
        cls.vm    = (dst_h > sh_int) ? AX_UP : (dst_h < sh_int) ? AX_DOWN : AX_PASS;
        cls.unity = (cls.hm == AX_PASS) && (cls.vm == AX_PASS);
        cls.code  = pick_code(cls.hm, cls.vm);
        cls.err   = frac_bad || (dst_w == '0) || (dst_h == '0) ||
                    (is_cursor && !cls.unity);
    end

    assign pix     = (sw_int > dst_w) ? sw_int : dst_w;
    assign pix_mul = (cls.vm == AX_DOWN) ? {1'b0, pix, 3'b000} : {pix, 4'b0000};
    assign lb_raw  = LB_W'(pix_mul) + LB_W'(31);
    assign lb_size = cls.unity ? '0 : {lb_raw[LB_W-1:5], 5'b00000};

endmodule

// File: rtl/scale_divider.sv
module scale_divider #(
    parameter int DW = 32,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quotient
);
    logic [DW-1:0] rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [DW:0]   shifted, diff;
    logic          fits;

    assign shifted = {rem_q, quo_q[DW-1]};
    assign diff    = shifted - {1'b0, den_q};
    assign fits    = shifted >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && cnt_q == '0) begin
                rem_q <= '0;
                quo_q <= dividend;
                den_q <= divisor;
                cnt_q <= CW'(DW);
            end else if (cnt_q != '0) begin
                rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
                quo_q <= {quo_q[DW-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> (rem_q < den_q)); // R7
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

endmodule

// File: rtl/scale_param_calc.sv
module scale_param_calc
    import scale_calc_pkg::*;
#(
    parameter int INT_W      = 16,
    parameter int FRAC_W     = 16,
    parameter int DN_SCALE_W = 21,
    parameter int UP_SCALE_W = 17,
    parameter int RECIP_W    = 16,
    localparam int COORD_W = INT_W + FRAC_W,
    localparam int LB_W    = INT_W + 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [COORD_W-1:0]    src_x,
    input  logic [COORD_W-1:0]    src_y,
    input  logic [COORD_W-1:0]    src_w,
    input  logic [COORD_W-1:0]    src_h,
    input  logic [INT_W-1:0]      dst_w,
    input  logic [INT_W-1:0]      dst_h,
    input  logic                  is_cursor,
    output logic                  out_valid,
    output logic                  out_err,
    output logic [2:0]            out_code,
    output logic                  out_unity,
    output logic [DN_SCALE_W-1:0] out_h_scale,
    output logic [DN_SCALE_W-1:0] out_v_scale,
    output logic [RECIP_W-1:0]    out_h_recip,
    output logic [RECIP_W-1:0]    out_v_recip,
    output logic [LB_W-1:0]       out_lb_size
);
    calc_state_e       state_q;
    logic [2:0]        op_q;
    cls_t              cls_in, cls_q;
    logic [LB_W-1:0]   lb_in, lb_q;
    logic [COORD_W-1:0] sw_q, sh_q, hq_q, vq_q, hr_q, vr_q;
    logic [INT_W-1:0]  dw_q, dh_q;
    logic              op_needed, div_start, div_done;
    logic [COORD_W-1:0] div_num, div_den, div_quo;
    logic              accept;

    scale_classify #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_classify (
        .src_x(src_x), .src_y(src_y), .src_w(src_w), .src_h(src_h),
        .dst_w(dst_w), .dst_h(dst_h), .is_cursor(is_cursor),
        .cls(cls_in), .lb_size(lb_in)
    );

    scale_divider #(.DW(COORD_W)) i_divider (
        .clk(clk), .rst(rst), .start(div_start),
        .dividend(div_num), .divisor(div_den),
        .done(div_done), .quotient(div_quo)
    );

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        op_needed = 1'b0;
        div_num   = '1;
        div_den   = '1;
        unique case (op_q)
            OP_HSCALE: begin
                op_needed = (cls_q.hm != AX_PASS);
                div_num   = sw_q;
                div_den   = COORD_W'(dw_q);
            end
            OP_VSCALE: begin
                op_needed = (cls_q.vm != AX_PASS);
                div_num   = sh_q;
                div_den   = COORD_W'(dh_q);
            end
            OP_HRECIP: begin
                op_needed = (cls_q.hm == AX_DOWN);
                div_den   = hq_q;
            end
            OP_VRECIP: begin
                op_needed = (cls_q.vm == AX_DOWN);
                div_den   = vq_q;
            end
            default: op_needed = 1'b0;
        endcase
    end

    assign div_start = (state_q == ST_LAUNCH) && (op_q != OP_END) && op_needed;

    function automatic logic [DN_SCALE_W-1:0] scale_field(axis_mode_e m,
                                                          logic [COORD_W-1:0] q);
        if (m == AX_DOWN) return q[DN_SCALE_W-1:0];
        if (m == AX_UP)   return DN_SCALE_W'(q[UP_SCALE_W-1:0]);
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_q        <= OP_HSCALE;
            cls_q       <= '0;
            lb_q        <= '0;
            sw_q        <= '0;
            sh_q        <= '0;
            dw_q        <= '0;
            dh_q        <= '0;
            hq_q        <= '0;
            vq_q        <= '0;
            hr_q        <= '0;
            vr_q        <= '0;
            out_valid   <= 1'b0;
            out_err     <= 1'b0;
            out_code    <= '0;
            out_unity   <= 1'b0;
            out_h_scale <= '0;
            out_v_scale <= '0;
            out_h_recip <= '0;
            out_v_recip <= '0;
            out_lb_size <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    cls_q   <= cls_in;
                    lb_q    <= lb_in;
                    sw_q    <= src_w;
                    sh_q    <= src_h;
                    dw_q    <= dst_w;
                    dh_q    <= dst_h;
                    op_q    <= OP_HSCALE;
                    state_q <= cls_in.err ? ST_DONE : ST_LAUNCH;
                end
                ST_LAUNCH: begin
                    if (op_q == OP_END)  state_q <= ST_DONE;
                    else if (op_needed)  state_q <= ST_WAIT;
                    else                 op_q    <= op_q + 3'd1;
                end
                ST_WAIT: if (div_done) begin
                    unique case (op_q)
                        OP_HSCALE: hq_q <= div_quo;
                        OP_VSCALE: vq_q <= div_quo;
                        OP_HRECIP: hr_q <= div_quo;
                        default:   vr_q <= div_quo;
                    endcase
                    op_q    <= op_q + 3'd1;
                    state_q <= ST_LAUNCH;
                end
                default: begin
                    out_valid   <= 1'b1;
                    out_err     <= cls_q.err;
                    out_code    <= cls_q.err ? 3'd0 : cls_q.code;
                    out_unity   <= !cls_q.err && cls_q.unity;
                    out_lb_size <= cls_q.err ? '0 : lb_q;
                    out_h_scale <= cls_q.err ? '0 : scale_field(cls_q.hm, hq_q);
                    out_v_scale <= cls_q.err ? '0 : scale_field(cls_q.vm, vq_q);
                    out_h_recip <= (!cls_q.err && cls_q.hm == AX_DOWN) ? hr_q[RECIP_W-1:0] : '0;
                    out_v_recip <= (!cls_q.err && cls_q.vm == AX_DOWN) ? vr_q[RECIP_W-1:0] : '0;
                    state_q     <= ST_IDLE;
                end
            endcase
        end
    end

    AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready); // R10
    AST_UNITY_NO_CODE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unity) |-> (out_code == 3'd0 && out_lb_size == '0)); // R3
    AST_LB_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lb_size[4:0] == 5'd0)); // R9
    AST_ERR_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_h_scale == '0 && out_v_scale == '0 &&
            out_h_recip == '0 && out_v_recip == '0 && out_lb_size == '0 && !out_unity)); // R11
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_h_scale) && $stable(out_v_scale) &&
            $stable(out_code) && $stable(out_lb_size) && $stable(out_err))); // R12

endmodule

// File: tb/test_scale_param_calc.sv
module test_scale_param_calc;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] src_x = '0, src_y = '0, src_w = '0, src_h = '0;
    logic [15:0] dst_w = '0, dst_h = '0;
    logic        is_cursor = 1'b0;
    logic        out_valid, out_err, out_unity;
    logic [2:0]  out_code;
    logic [20:0] out_h_scale, out_v_scale, out_lb_size;
    logic [15:0] out_h_recip, out_v_recip;

    scale_param_calc i_scale_param_calc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_x(src_x), .src_y(src_y), .src_w(src_w), .src_h(src_h),
        .dst_w(dst_w), .dst_h(dst_h), .is_cursor(is_cursor),
        .out_valid(out_valid), .out_err(out_err), .out_code(out_code),
        .out_unity(out_unity), .out_h_scale(out_h_scale), .out_v_scale(out_v_scale),
        .out_h_recip(out_h_recip), .out_v_recip(out_v_recip), .out_lb_size(out_lb_size)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    bit     m_ready = 1, m_ov = 0, acc_last = 0, have_cur = 0;
    int     m_cnt = 0;
    string  req_tag = "R1";
    // pending and current expected results
    longint p[8];
    longint c[8];
    string  p_tag;
    int     p_lat;

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int axis_kind(longint s, longint d);
        if (d > s) return 1;
        if (d < s) return 2;
        return 0;
    endfunction

    // p: 0 err,1 code,2 unity,3 hs,4 vs,5 hr,6 vr,7 lb
    task automatic model_compute();
        longint sw, sh, dw, dh, hsf, vsf, m;
        int hk, vk, ndiv;
        bit bad, uni;
        sw = longint'(src_w) >> 16;  sh = longint'(src_h) >> 16;
        dw = longint'(dst_w);        dh = longint'(dst_h);
        hk = axis_kind(sw, dw);      vk = axis_kind(sh, dh);
        uni = (hk == 0 && vk == 0);
        bad = (src_x[15:0] != 0) || (src_y[15:0] != 0) || (src_w[15:0] != 0) ||
              (src_h[15:0] != 0) || dw == 0 || dh == 0 || (is_cursor && !uni);
        foreach (p[i]) p[i] = 0;
        p_tag = req_tag;
        if (bad) begin
            p[0] = 1;
            p_lat = 1;
            return;
        end
        // R2 code table
        case ({hk[1:0], vk[1:0]})
            4'b0101: p[1] = 0;
            4'b1001: p[1] = 1;
            4'b0110: p[1] = 2;
            4'b1010: p[1] = 3;
            4'b0100: p[1] = 4;
            4'b0001: p[1] = 5;
            4'b0010: p[1] = 6;
            4'b1000: p[1] = 7;
            default: p[1] = 0;
        endcase
        p[2] = uni;
        hsf = (hk != 0) ? (sw * 65536) / dw : 0;
        vsf = (vk != 0) ? (sh * 65536) / dh : 0;
        p[3] = (hk == 2) ? (hsf & 64'h1FFFFF) : (hk == 1) ? (hsf & 64'h1FFFF) : 0;
        p[4] = (vk == 2) ? (vsf & 64'h1FFFFF) : (vk == 1) ? (vsf & 64'h1FFFF) : 0;
        p[5] = (hk == 2) ? ((64'hFFFFFFFF / hsf) & 64'hFFFF) : 0;
        p[6] = (vk == 2) ? ((64'hFFFFFFFF / vsf) & 64'hFFFF) : 0;
        m = (sw > dw) ? sw : dw;
        p[7] = uni ? 0 : ((((vk == 2) ? m * 8 : m * 16) + 31) / 32) * 32;
        ndiv = int'(hk != 0) + int'(vk != 0) + int'(hk == 2) + int'(vk == 2);
        p_lat = 6 + 33 * ndiv;
    endtask

    task automatic cmp_fields(input longint e[8], input string tg, input bit held);
        string pre;
        pre = held ? "R12 hold " : "";
        chk({pre, tg, " err"},   longint'(out_err),     e[0]);
        chk({pre, "R2 code"},    longint'(out_code),    e[1]);
        chk({pre, "R3 unity"},   longint'(out_unity),   e[2]);
        chk({pre, (e[0] != 0) ? "R11" : "R7", " h_scale"}, longint'(out_h_scale), e[3]);
        chk({pre, (e[0] != 0) ? "R11" : "R7", " v_scale"}, longint'(out_v_scale), e[4]);
        chk({pre, (e[0] != 0) ? "R11" : "R8", " h_recip"}, longint'(out_h_recip), e[5]);
        chk({pre, (e[0] != 0) ? "R11" : "R8", " v_recip"}, longint'(out_v_recip), e[6]);
        chk({pre, (e[0] != 0) ? "R11" : "R9", " lb_size"}, longint'(out_lb_size), e[7]);
    endtask

    // cycle-by-cycle reference, sampled 2 time units after each edge
    always @(posedge clk) begin
        #2;
        cycles++;
        if (rst) begin
            m_ready = 1; m_ov = 0; m_cnt = 0; acc_last = 0;
        end else begin
            acc_last = in_valid && m_ready;
            m_ov = 0;
            if (acc_last) begin
                model_compute();
                m_ready = 0;
                m_cnt = p_lat;
            end else if (!m_ready) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_ready = 1;
                    m_ov = 1;
                end
            end
            chk("R10 in_ready", longint'(in_ready), longint'(m_ready));
            chk("R10 out_valid", longint'(out_valid), longint'(m_ov));
            if (m_ov) begin
                cmp_fields(p, p_tag, 0);
                c = p;
                have_cur = 1;
            end else if (have_cur) begin
                cmp_fields(c, "R12", 1);
            end
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send(input string tag, input logic [31:0] sx, input logic [31:0] sy,
                        input logic [31:0] sw, input logic [31:0] sh,
                        input logic [15:0] dw, input logic [15:0] dh, input logic cur,
                        input int busy_poke);
        @(negedge clk);
        req_tag = tag;
        src_x = sx; src_y = sy; src_w = sw; src_h = sh;
        dst_w = dw; dst_h = dh; is_cursor = cur;
        in_valid = 1'b1;
        do @(negedge clk); while (!acc_last);
        in_valid = 1'b0;
        // R10: a request offered while busy must not be taken
        for (int k = 0; k < busy_poke; k++) begin
            in_valid = 1'b1;
            src_w = 32'h0003_0000; dst_w = 16'd1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (!m_ov) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] fx(input int v);
        return 32'(v) << 16;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R10 reset in_ready", longint'(in_ready), 1);
        chk("R10 reset out_valid", longint'(out_valid), 0);
        chk("R11 reset lb_size", longint'(out_lb_size), 0);
        rst = 1'b0;

        send("R3",  fx(10), fx(20), fx(100), fx(50), 16'd100, 16'd50, 1'b0, 0);
        send("R1",  fx(0),  fx(0),  fx(100), fx(50), 16'd200, 16'd100, 1'b0, 0);
        send("R1",  fx(1),  fx(2),  fx(300), fx(40), 16'd100, 16'd80, 1'b0, 0);
        send("R2",  fx(0),  fx(0),  fx(64),  fx(90), 16'd100, 16'd30, 1'b0, 10);
        send("R2",  fx(0),  fx(0),  fx(640), fx(480), 16'd320, 16'd240, 1'b0, 0);
        send("R2",  fx(0),  fx(0),  fx(7),   fx(9),  16'd13, 16'd9, 1'b0, 0);
        send("R2",  fx(0),  fx(0),  fx(50),  fx(33), 16'd50, 16'd99, 1'b0, 0);
        send("R2",  fx(0),  fx(0),  fx(50),  fx(99), 16'd50, 16'd33, 1'b0, 0);
        send("R2",  fx(0),  fx(0),  fx(99),  fx(20), 16'd33, 16'd20, 1'b0, 0);
        send("R9",  fx(0),  fx(0),  fx(3),   fx(4),  16'd5,  16'd4, 1'b0, 0);
        send("R7",  fx(0),  fx(0),  fx(4000), fx(65535), 16'd1, 16'd3, 1'b0, 0);
        send("R9",  fx(0),  fx(0),  fx(65535), fx(2), 16'd65534, 16'd1, 1'b0, 0);
        send("R4",  fx(0) | 32'h1, fx(0), fx(10), fx(10), 16'd20, 16'd20, 1'b0, 0);
        send("R4",  fx(0),  fx(0) | 32'h8000, fx(10), fx(10), 16'd20, 16'd20, 1'b0, 0);
        send("R4",  fx(0),  fx(0),  fx(10) | 32'h10, fx(10), 16'd10, 16'd10, 1'b0, 0);
        send("R4",  fx(0),  fx(0),  fx(10), fx(10) | 32'h1, 16'd10, 16'd10, 1'b0, 0);
        send("R5",  fx(0),  fx(0),  fx(64), fx(64), 16'd128, 16'd64, 1'b1, 0);
        send("R5",  fx(5),  fx(5),  fx(64), fx(64), 16'd64, 16'd64, 1'b1, 0);
        send("R6",  fx(0),  fx(0),  fx(64), fx(64), 16'd0, 16'd64, 1'b0, 0);
        send("R6",  fx(0),  fx(0),  fx(64), fx(64), 16'd64, 16'd0, 1'b0, 0);
        send("R1",  fx(0),  fx(0),  fx(1),  fx(1),  16'd2, 16'd2, 1'b0, 0);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule